// File: doc/BRIEF.md
# Pulse Density Modulation Threshold DAC

This block holds several 12-bit digital-to-analog channels. Each one turns a programmed code into a one-bit stream whose long-run fraction of ones equals the code divided by 4096. The streams are meant to drive external RC filters that set analog comparator thresholds. Only the digital stream generation and the register behaviour are built here.

Software reaches the block through a simple synchronous register port. A shared control word holds a global enable. Each channel has its own control word and its own data word. The control word carries a run enable and an output-routing enable. A channel produces a stream only while both the global enable and its own run enable are set. Every channel whose routing enable is set feeds one shared output pin, where the streams are merged.

Each modulator is a first-order error-feedback accumulator. On every clock it adds the code to a 12-bit accumulator and emits the carry. Codes are clamped on write to a safe window, so the stream never enters the sparse, low-transition patterns found near the ends of the range. A new code reaches the modulator only at the end of a 4096-cycle period.

Top module: `pdm_dac_top`

## Requirements
- R1: After reset, every control word reads 0, every data word reads 0x0CD, `pdm_out` is all zero and `pin_out` is 0.
- R2: A running channel with a constant active code C emits exactly C ones in any 4096 consecutive cycles on its `pdm_out` bit.
- R3: A 16-bit data write is clamped: any value below 0x0CD is stored as 0x0CD and any value above 0xF32 is stored as 0xF32. Values in between are stored unchanged. The stored value is what reads back and what drives the stream.
- R4: Bit 15 of the global word (address 0) gates all channels. While it is clear, all of `pdm_out` is 0, and the channel control words keep their values.
- R5: Bit 15 of a channel control word is its run enable. A channel whose run enable is clear outputs a constant 0 on `pdm_out`, even with the global enable set.
- R6: `pin_out` is registered. In each cycle it equals the OR, over the channels that are running and have bit 9 of their control word set, of those channels' `pdm_out` bits in the previous cycle.
- R7: A channel starts with a cleared accumulator each time it begins running. With code 0x800, its first four output bits after enabling are 0, 1, 0, 1.
- R8: A data write to a running channel takes effect only at the next 4096-cycle period boundary counted from when the channel started. Running from enable, the first period carries the old code in full and the next period carries the new code.
- R9: Address map: 0 is the global word, 1+2i is the control word of channel i, and 2+2i is the data word of channel i. `reg_rdata` is registered and shows the word at `reg_addr` one cycle later. A control word reads back only bits 15 and 9, a data word reads its code in bits 11:0, and any unmapped address reads 0.
- R10: A channel that has bit 9 set but is not running contributes nothing to `pin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (write and read) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for the previous cycle's address |
| pdm_out | output | NCH | Registered per-channel bitstreams |
| pin_out | output | 1 | Registered merge of the routed, running streams |

## Verification
The assertions assume that reset is asserted from time zero for at least one clock edge. They also assume that `reg_addr` and `reg_wdata` are stable around each rising edge, so every write lands on exactly one register and every code the modulators see has already been clamped. The bench drives all inputs on falling edges, holds reset for several cycles at start-up, and issues every write as a single-cycle strobe. The only values it writes outside the code window are the out-of-range codes used to test clamping.

// File: rtl/pdm_pkg.sv
`timescale 1ns/1ps
package pdm_pkg;
  localparam int CODE_W    = 12;
  localparam int REG_W     = 16;
  localparam int RUN_BIT   = 15;  // global and per-channel run enable
  localparam int ROUTE_BIT = 9;   // per-channel routing to the shared pin
  localparam logic [CODE_W-1:0] CODE_MIN = 12'h0CD;
  localparam logic [CODE_W-1:0] CODE_MAX = 12'hF32;

  // Hold a written word inside the usable code window.
  function automatic logic [CODE_W-1:0] clamp_code(input logic [REG_W-1:0] v);
    if (v < REG_W'(CODE_MIN))      return CODE_MIN;
    else if (v > REG_W'(CODE_MAX)) return CODE_MAX;
    else                           return v[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/pdm_regs.sv
`timescale 1ns/1ps
module pdm_regs
  import pdm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [REG_W-1:0]             wdata,
  output logic [REG_W-1:0]             rdata,
  output logic                         glob_en,
  output logic [NCH-1:0]               ch_en,
  output logic [NCH-1:0]               route,
  output logic [NCH-1:0][CODE_W-1:0]   code
);
  logic [REG_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en <= 1'b0;
      ch_en   <= '0;
      route   <= '0;
      for (int i = 0; i < NCH; i++) code[i] <= CODE_MIN;
    end else if (we) begin
      if (addr == '0) glob_en <= wdata[RUN_BIT];
      for (int i = 0; i < NCH; i++) begin
        if (addr == ADDR_W'(2*i+1)) begin
          ch_en[i] <= wdata[RUN_BIT];
          route[i] <= wdata[ROUTE_BIT];
        end
        if (addr == ADDR_W'(2*i+2)) code[i] <= clamp_code(wdata);
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == '0) rd_next[RUN_BIT] = glob_en;
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(2*i+1)) begin
        rd_next[RUN_BIT]   = ch_en[i];
        rd_next[ROUTE_BIT] = route[i];
      end
      if (addr == ADDR_W'(2*i+2)) rd_next[CODE_W-1:0] = code[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/pdm_mod.sv
`timescale 1ns/1ps
module pdm_mod
  import pdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code_in,
  output logic              bit_o,
  output logic [CODE_W-1:0] acc_o,
  output logic [CODE_W-1:0] code_o,
  output logic              wrap_o
);
  logic [CODE_W-1:0] acc_q;
  logic [CODE_W-1:0] act_q;
  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, act_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cnt_q <= '0;
      act_q <= CODE_MIN;
      bit_o <= 1'b0;
    end else if (!run) begin
      // idle: known phase, follow the programmed code
      acc_q <= '0;
      cnt_q <= '0;
      act_q <= code_in;
      bit_o <= 1'b0;
    end else begin
      acc_q <= sum[CODE_W-1:0];
      bit_o <= sum[CODE_W];
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '1) act_q <= code_in;  // accumulator back at zero here
    end
  end

  assign acc_o  = acc_q;
  assign code_o = act_q;
  assign wrap_o = (cnt_q == '1);
endmodule

// File: rtl/pdm_dac_top.sv
`timescale 1ns/1ps
module pdm_dac_top
  import pdm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = $clog2(2*NCH+2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [NCH-1:0]    pdm_out,
  output logic              pin_out
);
  logic                       glob_en;
  logic [NCH-1:0]             ch_en;
  logic [NCH-1:0]             route;
  logic [NCH-1:0]             run;
  logic [NCH-1:0][CODE_W-1:0] code;
  logic [NCH-1:0][CODE_W-1:0] acc_v;
  logic [NCH-1:0][CODE_W-1:0] act_v;
  logic [NCH-1:0]             wrap_v;

  pdm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .glob_en(glob_en), .ch_en(ch_en), .route(route),
    .code(code)
  );

  assign run = ch_en & {NCH{glob_en}};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pdm_mod u_mod (
      .clk(clk), .rst(rst), .run(run[i]), .code_in(code[i]),
      .bit_o(pdm_out[i]), .acc_o(acc_v[i]), .code_o(act_v[i]),
      .wrap_o(wrap_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pin_out <= 1'b0;
    else     pin_out <= |(pdm_out & route & run);
  end
endmodule

// File: rtl/pdm_dac_chk.sv
`timescale 1ns/1ps
module pdm_dac_chk
  import pdm_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NCH-1:0]             run,
  input logic [NCH-1:0]             route,
  input logic [NCH-1:0]             pdm_out,
  input logic                       pin_out,
  input logic [NCH-1:0][CODE_W-1:0] acc,
  input logic [NCH-1:0][CODE_W-1:0] act,
  input logic [NCH-1:0]             wrap
);
  // R6 and R10: shared pin merges last cycle's routed, running streams
  p_pin_merge_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pin_out == (|$past(pdm_out & route & run)));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R5 and R4: stopped channel is silent from the next cycle
    p_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
      !run[i] |=> !pdm_out[i]);
    // R3: the modulator only ever sees clamped codes
    p_code_window_r3: assert property (@(posedge clk) disable iff (rst)
      act[i] >= CODE_MIN && act[i] <= CODE_MAX);
    // R7: every run starts from a cleared accumulator
    p_start_phase_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(run[i]) |-> acc[i] == '0);
    // R8: the active code only changes at a period boundary
    p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
      run[i] && $past(run[i]) && !$past(wrap[i]) |-> $stable(act[i]));
  end
endmodule

bind pdm_dac_top pdm_dac_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .run(run), .route(route), .pdm_out(pdm_out),
  .pin_out(pin_out), .acc(acc_v), .act(act_v), .wrap(wrap_v)
);

// File: tb/test_pdm_dac_top.sv
`timescale 1ns/1ps
module test_pdm_dac_top;
  localparam int NCH = 4;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           reg_we = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [15:0]    reg_wdata = '0;
  logic [15:0]    reg_rdata;
  logic [NCH-1:0] pdm_out;
  logic           pin_out;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct { string req; int val; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  pdm_dac_top #(.NCH(NCH), .ADDR_W(AW)) i_pdm_dac_top (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pdm_out(pdm_out),
    .pin_out(pin_out)
  );

  // driver side: queue what the requirements predict
  task automatic push_exp(input string req, input int val);
    exp_t e;
    e.req = req; e.val = val;
    exp_q.push_back(e);
  endtask

  // monitor side: pop the oldest prediction and compare
  task automatic observe(input int actual);
    exp_t e;
    e = exp_q.pop_front();
    n_cmp++;
    if (actual != e.val) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", e.req, actual, e.val);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input int a, input int e);
    push_exp(req, e);
    @(negedge clk);
    reg_addr = AW'(a);
    @(negedge clk);
    observe(int'(reg_rdata));
  endtask

  // sel 0..NCH-1: one channel, NCH: OR of all channels, NCH+1: pin
  task automatic count_ones(input int sel, input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      if (sel < NCH)       c += int'(pdm_out[sel]);
      else if (sel == NCH) c += int'(|pdm_out);
      else                 c += int'(pin_out);
    end
  endtask

  task automatic pin_window(input logic [NCH-1:0] mask, input int n, output int bad);
    logic prev;
    bad = 0;
    prev = |(pdm_out & mask);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      if (pin_out !== prev) bad++;
      prev = |(pdm_out & mask);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int c;
    int c2;
    logic [3:0] pat;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    push_exp("R1 pdm_out", 0); observe(int'(pdm_out));
    push_exp("R1 pin_out", 0); observe(int'(pin_out));
    rd_check("R1 global word", 0, 0);
    for (int i = 0; i < NCH; i++) begin
      rd_check("R1 control word", 2*i+1, 0);
      rd_check("R1 data word", 2*i+2, 16'h0CD);
    end

    // R7: known start phase, code 0x800 -> 0,1,0,1
    wr(2, 16'h800);
    wr(1, 16'h8200);
    wr(0, 16'h8000);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      pat[k] = pdm_out[0];
    end
    push_exp("R7 first bits", 4'b1010); observe(int'(pat));

    // R2: density over 4096 cycles; R6: single routed channel on the pin
    count_ones(0, 4096, c);
    push_exp("R2 ch0 density 0x800", 2048); observe(c);
    count_ones(NCH+1, 4096, c);
    push_exp("R6 pin density single route", 2048); observe(c);

    // R2: second pattern on channel 1
    wr(4, 16'h4D9);
    wr(3, 16'h8000);
    count_ones(1, 4096, c);
    push_exp("R2 ch1 density 0x4D9", 16'h4D9); observe(c);

    // R6: two routed streams merge by OR
    wr(3, 16'h8200);
    pin_window(4'b0011, 4096, c);
    push_exp("R6 pin merge mismatches", 0); observe(c);

    // R3: clamping at both ends, in-range pass-through, stream uses clamped value
    wr(6, 16'h0010);
    rd_check("R3 low clamp", 6, 16'h0CD);
    wr(6, 16'h0CE);
    rd_check("R3 in range", 6, 16'h0CE);
    wr(6, 16'hFFFF);
    rd_check("R3 high clamp", 6, 16'hF32);
    wr(5, 16'h8000);
    count_ones(2, 4096, c);
    push_exp("R3 clamped stream density", 16'hF32); observe(c);

    // R5 and R10: routed but stopped channel is silent and adds nothing to the pin
    wr(1, 16'h8000);
    wr(3, 16'h8000);
    wr(7, 16'h0200);
    count_ones(3, 256, c);
    push_exp("R5 stopped channel output", 0); observe(c);
    count_ones(NCH+1, 256, c);
    push_exp("R10 pin with only stopped route", 0); observe(c);

    // R4: global enable gates all channels, channel words retained
    wr(0, 16'h0000);
    @(negedge clk);
    count_ones(NCH, 256, c);
    push_exp("R4 all outputs with global off", 0); observe(c);
    rd_check("R4 control word retained", 1, 16'h8000);
    wr(0, 16'h8000);

    // R8: mid-period write waits for the period boundary
    wr(1, 16'h0000);
    wr(2, 16'h300);
    wr(1, 16'h8000);
    c = 0; c2 = 0;
    for (int k = 0; k < 8192; k++) begin
      if (k == 100) begin reg_we = 1'b1; reg_addr = AW'(2); reg_wdata = 16'hA00; end
      if (k == 101) reg_we = 1'b0;
      @(posedge clk); @(negedge clk);
      if (k < 4096) c  += int'(pdm_out[0]);
      else          c2 += int'(pdm_out[0]);
    end
    push_exp("R8 first period old code", 16'h300); observe(c);
    push_exp("R8 second period new code", 16'hA00); observe(c2);
    rd_check("R3 stored in-range code", 2, 16'hA00);

    // R9: read-back masking and unmapped address
    wr(7, 16'hFFFF);
    rd_check("R9 control read mask", 7, 16'h8200);
    rd_check("R9 unmapped address", 9, 0);
    rd_check("R9 global word", 0, 16'h8000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule